// File: doc/BRIEF.md
# Double-Buffered Cache Snapshot Controller

This block sits next to one cache and keeps a power-safe copy of its contents in two non-volatile snapshot banks, called bank 0 and bank 1. A small persistent word holds two flags: a selector that names the bank with the last good snapshot, and a "copy in flight" flag. While the global checkpoint request is high, the controller reads the cache one line at a time and writes each line into the bank that the selector does not name. It flips the selector only after the whole copy has finished and the request has dropped. A power loss during a copy therefore always leaves the previous snapshot intact.

After power returns, a recover pulse makes the controller restore the cache from the bank that the selector names, again one line at a time. If the in-flight flag shows that a copy was cut short, that partial bank is abandoned and the flag is cleared. The cache, the two banks and the persistent word are all external, and each is reached through a plain synchronous port. A read issued in one cycle returns its data in the next cycle.

Top module: `cache_snap_ctrl`

## Requirements
- R1: After a synchronous reset the block is idle. No cache, bank or persistent write is issued and `done_o` stays low until a request or a recover pulse arrives.
- R2: While `ckpt_req_i` is high, an idle block copies every cache line i (0..NUM_LINES-1) to line i of the target bank, with exactly one bank write per line. `done_o` is a single-cycle pulse, raised once after line NUM_LINES-1 has been written.
- R3: The target bank of a copy is the complement of the persistent selector (`bank_sel_o` = 0 means bank 0, 1 means bank 1). The bank that the selector names is never written by a copy.
- R4: When a copy starts, the persistent word is written once with the in-flight flag set to 1 and the selector unchanged.
- R5: The commit is one persistent write with selector = target and flag = 0. It is issued only after the copy is done and `ckpt_req_i` has been seen low. While the request stays high the commit waits.
- R6: The persistent selector never changes except through the commit of R5. A reset during a copy leaves the selector at its old value and the in-flight flag at 1.
- R7: A `recover_i` pulse in idle restores every cache line i from line i of the bank that the selector names, with one cache write per line, and then pulses `done_o`.
- R8: If the in-flight flag is 1 at recovery, the restore still reads the bank that the selector names (the older snapshot). The flag is then cleared by one persistent write that keeps the selector.
- R9: A checkpoint request seen during a restore is held off. No bank write occurs until the restore has finished, and the copy then runs even if the request has dropped in the meantime.
- R10: When `recover_i` and `ckpt_req_i` are both seen in the same idle cycle, the restore runs first and the copy follows it.
- R11: A `recover_i` pulse during a copy is ignored. No cache write occurs and the copy completes normally.
- R12: A cache write and a bank write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (models power loss; persistent state is external) |
| ckpt_req_i | input | 1 | Global checkpoint request, level |
| recover_i | input | 1 | Start-restore pulse after power-up |
| done_o | output | 1 | One-cycle pulse when a copy or a restore has finished its last line |
| cache_addr_o | output | AW | Cache line index |
| cache_re_o | output | 1 | Cache read strobe |
| cache_rdata_i | input | LINE_W | Cache read data, one cycle after the strobe |
| cache_we_o | output | 1 | Cache write strobe |
| cache_wdata_o | output | LINE_W | Cache write data |
| bank_sel_o | output | 1 | Snapshot bank addressed (0 or 1) |
| bank_addr_o | output | AW | Snapshot line index |
| bank_re_o | output | 1 | Snapshot read strobe |
| bank_rdata_i | input | LINE_W | Snapshot read data, one cycle after the strobe |
| bank_we_o | output | 1 | Snapshot write strobe |
| bank_wdata_o | output | LINE_W | Snapshot write data |
| nv_sel_i | input | 1 | Persistent selector: bank holding the valid snapshot |
| nv_busy_i | input | 1 | Persistent in-flight flag |
| nv_we_o | output | 1 | Persistent word write strobe |
| nv_wsel_o | output | 1 | Selector value to write |
| nv_wbusy_o | output | 1 | In-flight flag value to write |

## Verification
The interesting collision is a recover pulse and a checkpoint request landing in the same idle cycle, together with its near relatives: a request that rises and falls inside a restore, and a recover pulse in the middle of a copy. The bench drives these cases on the same falling edge or a fixed number of cycles apart. It records at the memory ports which kind of write appears first and how many writes of each kind fall in each window. It then checks the cache and both banks line by line against patterns computed from the line index and the round number.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COPY,
    ST_HOLD,
    ST_SETTLE,
    ST_REST
  } snap_state_e;
endpackage

// File: rtl/snap_mover.sv
// Streams NUM_LINES words from a read port (1-cycle latency) to a write port.
module snap_mover #(
  parameter int NUM_LINES = 64,
  parameter int LINE_W    = 32,
  localparam int AW       = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [LINE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [LINE_W-1:0] wr_data_o,
  output logic              fin_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_LINES - 1);

  logic          d_vld;
  logic [AW-1:0] d_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      d_vld     <= 1'b0;
      d_addr    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      fin_o     <= 1'b0;
    end else begin
      fin_o     <= wr_en_o && (wr_addr_o == LAST);
      wr_en_o   <= d_vld;
      wr_addr_o <= d_addr;
      wr_data_o <= rd_data_i;
      d_vld     <= rd_en_o;
      d_addr    <= rd_addr_o;
      if (start_i) begin
        rd_en_o   <= 1'b1;
        rd_addr_o <= '0;
      end else if (rd_en_o) begin
        if (rd_addr_o == LAST) rd_en_o <= 1'b0;
        else                   rd_addr_o <= rd_addr_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/snap_seq.sv
// Sequencing of copy, commit and restore, plus persistent word updates.
module snap_seq
  import snap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ckpt_req_i,
  input  logic recover_i,
  input  logic nv_sel_i,
  input  logic nv_busy_i,
  input  logic mv_fin_i,
  output logic mv_start_o,
  output logic op_copy_o,
  output logic bank_sel_o,
  output logic nv_we_o,
  output logic nv_wsel_o,
  output logic nv_wbusy_o
);
  snap_state_e st;
  logic        pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      pend       <= 1'b0;
      mv_start_o <= 1'b0;
      op_copy_o  <= 1'b0;
      bank_sel_o <= 1'b0;
      nv_we_o    <= 1'b0;
      nv_wsel_o  <= 1'b0;
      nv_wbusy_o <= 1'b0;
    end else begin
      mv_start_o <= 1'b0;
      nv_we_o    <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (recover_i) begin
            st         <= ST_REST;
            op_copy_o  <= 1'b0;
            bank_sel_o <= nv_sel_i;
            mv_start_o <= 1'b1;
            pend       <= pend | ckpt_req_i;
            if (nv_busy_i) begin
              nv_we_o    <= 1'b1;
              nv_wsel_o  <= nv_sel_i;
              nv_wbusy_o <= 1'b0;
            end
          end else if (ckpt_req_i || pend) begin
            st         <= ST_COPY;
            op_copy_o  <= 1'b1;
            bank_sel_o <= ~nv_sel_i;
            mv_start_o <= 1'b1;
            pend       <= 1'b0;
            nv_we_o    <= 1'b1;
            nv_wsel_o  <= nv_sel_i;
            nv_wbusy_o <= 1'b1;
          end
        end
        ST_COPY: begin
          if (mv_fin_i) st <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!ckpt_req_i) begin
            st         <= ST_SETTLE;
            nv_we_o    <= 1'b1;
            nv_wsel_o  <= bank_sel_o;
            nv_wbusy_o <= 1'b0;
          end
        end
        ST_SETTLE: st <= ST_IDLE;
        ST_REST: begin
          pend <= pend | ckpt_req_i;
          if (mv_fin_i) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_snap_ctrl.sv
module cache_snap_ctrl #(
  parameter int NUM_LINES = 64,
  parameter int LINE_W    = 32,
  localparam int AW       = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ckpt_req_i,
  input  logic              recover_i,
  output logic              done_o,
  output logic [AW-1:0]     cache_addr_o,
  output logic              cache_re_o,
  input  logic [LINE_W-1:0] cache_rdata_i,
  output logic              cache_we_o,
  output logic [LINE_W-1:0] cache_wdata_o,
  output logic              bank_sel_o,
  output logic [AW-1:0]     bank_addr_o,
  output logic              bank_re_o,
  input  logic [LINE_W-1:0] bank_rdata_i,
  output logic              bank_we_o,
  output logic [LINE_W-1:0] bank_wdata_o,
  input  logic              nv_sel_i,
  input  logic              nv_busy_i,
  output logic              nv_we_o,
  output logic              nv_wsel_o,
  output logic              nv_wbusy_o
);
  logic              mv_start, mv_fin, op_copy;
  logic              mv_rd_en, mv_wr_en;
  logic [AW-1:0]     mv_rd_addr, mv_wr_addr;
  logic [LINE_W-1:0] mv_rd_data, mv_wr_data;

  snap_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .ckpt_req_i (ckpt_req_i),
    .recover_i  (recover_i),
    .nv_sel_i   (nv_sel_i),
    .nv_busy_i  (nv_busy_i),
    .mv_fin_i   (mv_fin),
    .mv_start_o (mv_start),
    .op_copy_o  (op_copy),
    .bank_sel_o (bank_sel_o),
    .nv_we_o    (nv_we_o),
    .nv_wsel_o  (nv_wsel_o),
    .nv_wbusy_o (nv_wbusy_o)
  );

  snap_mover #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_mover (
    .clk       (clk),
    .rst       (rst),
    .start_i   (mv_start),
    .rd_en_o   (mv_rd_en),
    .rd_addr_o (mv_rd_addr),
    .rd_data_i (mv_rd_data),
    .wr_en_o   (mv_wr_en),
    .wr_addr_o (mv_wr_addr),
    .wr_data_o (mv_wr_data),
    .fin_o     (mv_fin)
  );

  // Direction routing: copy reads cache / writes bank, restore the reverse.
  assign mv_rd_data    = op_copy ? cache_rdata_i : bank_rdata_i;
  assign cache_re_o    = op_copy & mv_rd_en;
  assign cache_we_o    = ~op_copy & mv_wr_en;
  assign cache_addr_o  = op_copy ? mv_rd_addr : mv_wr_addr;
  assign cache_wdata_o = mv_wr_data;
  assign bank_re_o     = ~op_copy & mv_rd_en;
  assign bank_we_o     = op_copy & mv_wr_en;
  assign bank_addr_o   = op_copy ? mv_wr_addr : mv_rd_addr;
  assign bank_wdata_o  = mv_wr_data;
  assign done_o        = mv_fin;
endmodule

// File: rtl/cache_snap_ctrl_chk.sv
module cache_snap_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ckpt_req_i,
  input logic done_o,
  input logic cache_we_o,
  input logic bank_sel_o,
  input logic bank_re_o,
  input logic bank_we_o,
  input logic nv_sel_i,
  input logic nv_we_o,
  input logic nv_wsel_o,
  input logic nv_wbusy_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R2
  AST_COPY_TO_OTHER_BANK: assert property (@(posedge clk) disable iff (rst)
    bank_we_o |-> (bank_sel_o != nv_sel_i)); // R3
  AST_START_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
    (nv_we_o && nv_wbusy_o) |-> (nv_wsel_o == nv_sel_i)); // R4
  AST_COMMIT_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (nv_we_o && (nv_wsel_o != nv_sel_i)) |-> (!nv_wbusy_o && !$past(ckpt_req_i))); // R5
  AST_SEL_ONLY_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (nv_we_o && (nv_wsel_o != nv_sel_i)) |-> (nv_wsel_o == bank_sel_o)); // R6
  AST_RESTORE_FROM_SEL: assert property (@(posedge clk) disable iff (rst)
    bank_re_o |-> (bank_sel_o == nv_sel_i)); // R8
  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(cache_we_o && bank_we_o)); // R12
endmodule

bind cache_snap_ctrl cache_snap_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ckpt_req_i (ckpt_req_i),
  .done_o     (done_o),
  .cache_we_o (cache_we_o),
  .bank_sel_o (bank_sel_o),
  .bank_re_o  (bank_re_o),
  .bank_we_o  (bank_we_o),
  .nv_sel_i   (nv_sel_i),
  .nv_we_o    (nv_we_o),
  .nv_wsel_o  (nv_wsel_o),
  .nv_wbusy_o (nv_wbusy_o)
);

// File: tb/cache_snap_ctrl_test.sv
`timescale 1ns/1ps
module cache_snap_ctrl_test;
  localparam int NL = 8;
  localparam int DW = 16;
  localparam int AW = $clog2(NL);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, rec = 1'b0;
  logic done;
  logic [AW-1:0] c_addr, b_addr;
  logic c_re, c_we, b_sel, b_re, b_we, nv_we, nv_wsel, nv_wbusy;
  logic [DW-1:0] c_rd, c_wd, b_rd, b_wd;

  // memory models (persistent across rst)
  logic [DW-1:0] cmem [NL];
  logic [DW-1:0] bmem0 [NL];
  logic [DW-1:0] bmem1 [NL];
  logic nv_sel = 1'b0, nv_busy = 1'b0;

  // backdoor load, applied in the memory process
  logic ld_en = 1'b0;
  logic [1:0] ld_tgt = '0;
  logic [AW-1:0] ld_a = '0;
  logic [DW-1:0] ld_d = '0;

  // port monitors
  logic clr = 1'b0;
  int cw_n = 0, bw_n = 0, nv_n = 0, done_n = 0, both_n = 0, first_k = 0;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  cache_snap_ctrl #(.NUM_LINES(NL), .LINE_W(DW)) uut (
    .clk(clk), .rst(rst), .ckpt_req_i(req), .recover_i(rec), .done_o(done),
    .cache_addr_o(c_addr), .cache_re_o(c_re), .cache_rdata_i(c_rd),
    .cache_we_o(c_we), .cache_wdata_o(c_wd),
    .bank_sel_o(b_sel), .bank_addr_o(b_addr), .bank_re_o(b_re),
    .bank_rdata_i(b_rd), .bank_we_o(b_we), .bank_wdata_o(b_wd),
    .nv_sel_i(nv_sel), .nv_busy_i(nv_busy), .nv_we_o(nv_we),
    .nv_wsel_o(nv_wsel), .nv_wbusy_o(nv_wbusy));

  always @(posedge clk) begin
    if (ld_en) begin
      if (ld_tgt == 2'd0) cmem[ld_a] <= ld_d;
      else if (ld_tgt == 2'd1) bmem0[ld_a] <= ld_d;
      else bmem1[ld_a] <= ld_d;
    end
    if (c_we) cmem[c_addr] <= c_wd;
    if (c_re) c_rd <= cmem[c_addr];
    if (b_we) begin
      if (b_sel) bmem1[b_addr] <= b_wd;
      else bmem0[b_addr] <= b_wd;
    end
    if (b_re) b_rd <= b_sel ? bmem1[b_addr] : bmem0[b_addr];
    if (nv_we) begin
      nv_sel  <= nv_wsel;
      nv_busy <= nv_wbusy;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      cw_n <= 0; bw_n <= 0; nv_n <= 0; done_n <= 0; both_n <= 0; first_k <= 0;
    end else begin
      if (c_we) cw_n <= cw_n + 1;
      if (b_we) bw_n <= bw_n + 1;
      if (nv_we) nv_n <= nv_n + 1;
      if (done) done_n <= done_n + 1;
      if (c_we && b_we) both_n <= both_n + 1;
      if (first_k == 0 && c_we) first_k <= 1;
      else if (first_k == 0 && b_we) first_k <= 2;
    end
  end

  function automatic logic [DW-1:0] pat(int rnd, int i);
    return DW'(rnd * 16'h1111 + i * 16'h0107 + 16'h0035);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic load(int tgt, int rnd);
    for (int i = 0; i < NL; i++) begin
      ld_en = 1'b1; ld_tgt = 2'(tgt); ld_a = AW'(i); ld_d = pat(rnd, i);
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic clear_mon();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_done(string tag, int target);
    int n = 0;
    while (done_n < target && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) chk({tag, " timeout"}, done_n, target);
  endtask

  task automatic cmp_mem(string tag, int which, int rnd);
    int bad = 0;
    for (int i = 0; i < NL; i++) begin
      logic [DW-1:0] v;
      v = (which == 0) ? cmem[i] : (which == 1) ? bmem0[i] : bmem1[i];
      if (v != pat(rnd, i)) begin
        bad++;
        $display("FAIL %s line %0d: actual %h expected %h", tag, i, v, pat(rnd, i));
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic pulse_rec();
    rec = 1'b1; @(negedge clk); rec = 1'b0;
  endtask

  // watchdog
  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    load(1, 10); load(2, 11); load(0, 1);
    tick(2); rst = 1'b0; clear_mon();
    // R1: idle after reset
    tick(6);
    chk("R1 done", done_n, 0);
    chk("R1 cache writes", cw_n, 0);
    chk("R1 bank writes", bw_n, 0);
    chk("R1 nv writes", nv_n, 0);

    // copy #1: selector 0 -> target bank 1
    clear_mon(); req = 1'b1;
    wait_done("R2 copy1", 1);
    tick(4);
    chk("R2 single done", done_n, 1);
    chk("R2 one write per line", bw_n, NL);
    cmp_mem("R2 bank1 holds cache", 2, 1);
    cmp_mem("R3 bank0 untouched", 1, 10);
    chk("R4 flag set", int'(nv_busy), 1);
    chk("R4 sel kept", int'(nv_sel), 0);
    chk("R5 commit waits for fall", nv_n, 1);
    req = 1'b0; tick(4);
    chk("R5 sel flipped", int'(nv_sel), 1);
    chk("R5 flag cleared", int'(nv_busy), 0);
    chk("R5 nv writes", nv_n, 2);

    // restore from bank 1
    load(0, 2); clear_mon(); pulse_rec();
    wait_done("R7 restore", 1); tick(2);
    cmp_mem("R7 cache restored", 0, 1);
    chk("R7 one write per line", cw_n, NL);
    chk("R7 no nv write when clean", nv_n, 0);

    // power loss during copy #2
    load(0, 3); clear_mon(); req = 1'b1;
    tick(6); rst = 1'b1; tick(2); req = 1'b0; rst = 1'b0; tick(2);
    chk("R6 sel kept after loss", int'(nv_sel), 1);
    chk("R6 flag left set", int'(nv_busy), 1);
    clear_mon(); pulse_rec();
    wait_done("R8 restore", 1); tick(2);
    cmp_mem("R8 older bank used", 0, 1);
    chk("R8 flag cleared", int'(nv_busy), 0);
    chk("R8 sel unchanged", int'(nv_sel), 1);
    chk("R8 one nv write", nv_n, 1);

    // R9: short request inside a restore
    load(0, 4); clear_mon(); pulse_rec();
    tick(2); req = 1'b1; @(negedge clk); req = 1'b0;
    wait_done("R9 restore", 1);
    chk("R9 no bank write in restore", bw_n, 0);
    cmp_mem("R9 cache restored", 0, 1);
    wait_done("R9 deferred copy", 2); tick(4);
    cmp_mem("R9 deferred copy to bank0", 1, 1);
    chk("R9 sel after commit", int'(nv_sel), 0);

    // R10: recover and request together
    load(0, 5); load(1, 6); clear_mon();
    rec = 1'b1; req = 1'b1; @(negedge clk); rec = 1'b0;
    wait_done("R10 first", 2); tick(3);
    chk("R10 restore first", first_k, 1);
    cmp_mem("R10 cache from bank0", 0, 6);
    cmp_mem("R10 bank1 copy", 2, 6);
    req = 1'b0; tick(4);
    chk("R10 sel after commit", int'(nv_sel), 1);

    // R11: recover during copy
    load(0, 7); clear_mon(); req = 1'b1;
    tick(3); pulse_rec();
    wait_done("R11 copy", 1); tick(3);
    chk("R11 no cache write", cw_n, 0);
    cmp_mem("R11 cache intact", 0, 7);
    cmp_mem("R11 bank0 copy", 1, 7);
    chk("R11 single done", done_n, 1);
    req = 1'b0; tick(4);
    chk("R11 sel after commit", int'(nv_sel), 0);
    chk("R12 no dual write", both_n, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule